// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block takes configuration writes over a three-line serial port made of a data line, a shift clock line and a latch line, with an active-low select. While the select is low, each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. A rising edge on the latch line then commits the collected word. Bits [11:9] of the word choose the target register, and bits [8:0] give its new contents. The decoded control fields drive the rest of the converter continuously.

All four serial inputs are brought into the system clock domain through a synchronizer chain. Edges are found by comparing each synchronized line with its value one system clock earlier. A fifth register, which holds the differential output mode and the clock-loss-detector disable, stays write-protected until a key value has been written into spare bits of mode register A. A later write with any other key protects it again.

Top module: `ctl3w_port`

## Requirements
- R1: After reset both attenuation values are 0xFF. Every other control output is 0, and the hidden register is locked.
- R2: A frame is 16 bits, sent MSB first. Outputs change only after a rising latch edge and do not change while bits are being shifted in.
- R3: Address 000 writes the left attenuation from bits [7:0] and the left load bit from bit 8. Address 001 does the same for the right channel.
- R4: Address 010 (mode register A) sets these fields: soft mute from bit 0, de-emphasis enable from bit 1, force-zero from bit 2 and word length from bits [4:3].
- R5: Address 011 (mode register B) sets these fields: I2S format from bit 0, frame-clock polarity from bit 1, common attenuation from bit 2, slow roll-off from bit 3, phase reverse from bit 4, clock-out divide from bit 5, de-emphasis rate from bits [7:6] and zero-detect enable from bit 8.
- R6: While the hidden register is locked, a write to address 110 leaves the differential mode and the clock-loss disable unchanged.
- R7: Writing mode register A with bits [8:5] = 1111 unlocks the hidden register. After that, address 110 sets the differential mode from bits [5:4] and the clock-loss disable from bit 6.
- R8: Writing mode register A with bits [8:5] set to any value other than 1111 locks the hidden register again.
- R9: While the select is high, shift clock edges and latch edges have no effect.
- R10: Writes to addresses 100, 101 and 111 change no output and do not change the lock state.
- R11: If more or fewer than 16 bits were shifted since the last latch, the most recent bits received form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low port select |
| ser_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Rising edge commits the shifted word |
| atten_l | output | 8 | Left attenuation code |
| load_l | output | 1 | Left attenuation load bit |
| atten_r | output | 8 | Right attenuation code |
| load_r | output | 1 | Right attenuation load bit |
| soft_mute | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| force_zero | output | 1 | Forces the converter output to bipolar zero |
| word_len | output | 2 | Input word length select |
| fmt_i2s | output | 1 | I2S audio format select |
| lr_pol | output | 1 | Frame-clock polarity |
| atten_common | output | 1 | Use left attenuation for both channels |
| slow_rolloff | output | 1 | Slow filter roll-off select |
| phase_rev | output | 1 | Output phase reverse |
| clkout_div | output | 1 | Clock-out divide-by-two select |
| deemph_rate | output | 2 | De-emphasis sample-rate select |
| zero_det_en | output | 1 | Zero-detect mute enable |
| diff_mode | output | 2 | Differential output mode (hidden register) |
| clkloss_dis | output | 1 | Clock-loss detector disable (hidden register) |

## Verification
The hardest state to reach from the ports is the hidden register's lock. The lock cannot be observed directly, so it can only be inferred from whether a later write to address 110 moves the differential mode outputs. The stimulus first writes address 110 while the register is locked. It then writes the key into mode register A and sweeps every hidden-register value. Next it writes non-key values into the same spare bits and repeats the hidden write. Partial and overlong frames are also hard to reach: they are made by shifting 20 bits, and then 12 bits, before a latch. The expected word in each case comes from a model of the most recent bits received.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int ATT_W    = 8;
    localparam int ADDR_LSB = 9;
    localparam int ADDR_W   = 3;
    localparam int WORD_W   = ADDR_LSB + ADDR_W;
    localparam int KEY_LSB  = 5;
    localparam int KEY_W    = 4;

    localparam logic [KEY_W-1:0] UNLOCK_KEY = '1;

    typedef enum logic [ADDR_W-1:0] {
        A_ATT_L  = 3'b000,
        A_ATT_R  = 3'b001,
        A_MODE_A = 3'b010,
        A_MODE_B = 3'b011,
        A_HIDDEN = 3'b110
    } reg_addr_e;

    typedef struct packed {
        logic [ATT_W-1:0] atten_l;
        logic             load_l;
        logic [ATT_W-1:0] atten_r;
        logic             load_r;
        logic             soft_mute;
        logic             deemph_en;
        logic             force_zero;
        logic [1:0]       word_len;
        logic             fmt_i2s;
        logic             lr_pol;
        logic             atten_common;
        logic             slow_rolloff;
        logic             phase_rev;
        logic             clkout_div;
        logic [1:0]       deemph_rate;
        logic             zero_det_en;
        logic [1:0]       diff_mode;
        logic             clkloss_dis;
    } ctl_regs_t;

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              latch_s,
    input  logic              cs_n_s,
    output logic [WORD_W-1:0] word_o,
    output logic              wr_stb_o
);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic              sclk_prev;
        logic              latch_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      shift_en;

    always_comb begin
        st_d            = st_q;
        st_d.sclk_prev  = sclk_s;
        st_d.latch_prev = latch_s;
        shift_en        = sclk_s && !st_q.sclk_prev && !cs_n_s;
        if (shift_en) begin
            st_d.shreg = {st_q.shreg[WORD_W-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.shreg      <= '0;
            st_q.sclk_prev  <= 1'b1;
            st_q.latch_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.shreg;
    assign wr_stb_o = latch_s && !st_q.latch_prev && !cs_n_s;

    // deselected port holds its shift register
    p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(st_q.shreg));

    // newest bit enters at the LSB end, so the first bit ends up as MSB
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !st_q.sclk_prev && !cs_n_s) |=> (st_q.shreg[0] == $past(sdat_s)));

endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] word,
    output ctl_regs_t         regs_o
);

    typedef struct packed {
        ctl_regs_t r;
        logic      unlocked;
    } bank_st_t;

    bank_st_t            st_d, st_q;
    logic [ADDR_W-1:0]   addr;
    logic [ADDR_LSB-1:0] data;

    assign addr = word[ADDR_LSB +: ADDR_W];
    assign data = word[ADDR_LSB-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            case (addr)
                A_ATT_L: begin
                    st_d.r.atten_l = data[ATT_W-1:0];
                    st_d.r.load_l  = data[ATT_W];
                end
                A_ATT_R: begin
                    st_d.r.atten_r = data[ATT_W-1:0];
                    st_d.r.load_r  = data[ATT_W];
                end
                A_MODE_A: begin
                    st_d.r.soft_mute  = data[0];
                    st_d.r.deemph_en  = data[1];
                    st_d.r.force_zero = data[2];
                    st_d.r.word_len   = data[4:3];
                    st_d.unlocked     = (data[KEY_LSB +: KEY_W] == UNLOCK_KEY);
                end
                A_MODE_B: begin
                    st_d.r.fmt_i2s      = data[0];
                    st_d.r.lr_pol       = data[1];
                    st_d.r.atten_common = data[2];
                    st_d.r.slow_rolloff = data[3];
                    st_d.r.phase_rev    = data[4];
                    st_d.r.clkout_div   = data[5];
                    st_d.r.deemph_rate  = data[7:6];
                    st_d.r.zero_det_en  = data[8];
                end
                A_HIDDEN: begin
                    if (st_q.unlocked) begin
                        st_d.r.diff_mode   = data[5:4];
                        st_d.r.clkloss_dis = data[6];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.r.atten_l <= '1;
            st_q.r.atten_r <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.r;

    // registers move only on a commit strobe
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(st_q.r));

    // hidden fields frozen while locked
    p_hidden_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.unlocked |=> ($stable(st_q.r.diff_mode) && $stable(st_q.r.clkloss_dis)));

    // unused codes touch nothing
    p_unused_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (addr == 3'b100 || addr == 3'b101 || addr == 3'b111))
        |=> ($stable(st_q.r) && $stable(st_q.unlocked)));

    // non-key write to mode register A leaves the bank locked
    p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && addr == A_MODE_A && data[KEY_LSB +: KEY_W] != UNLOCK_KEY) |=> !st_q.unlocked);

endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_latch,
    output logic [ATT_W-1:0] atten_l,
    output logic             load_l,
    output logic [ATT_W-1:0] atten_r,
    output logic             load_r,
    output logic             soft_mute,
    output logic             deemph_en,
    output logic             force_zero,
    output logic [1:0]       word_len,
    output logic             fmt_i2s,
    output logic             lr_pol,
    output logic             atten_common,
    output logic             slow_rolloff,
    output logic             phase_rev,
    output logic             clkout_div,
    output logic [1:0]       deemph_rate,
    output logic             zero_det_en,
    output logic [1:0]       diff_mode,
    output logic             clkloss_dis
);

    localparam int NLINES = 4;

    logic [NLINES-1:0] lines_raw;
    logic [NLINES-1:0] lines_s;
    logic [WORD_W-1:0] word;
    logic              wr_stb;
    ctl_regs_t         regs;

    assign lines_raw = {cs_n, ser_clk, ser_latch, ser_dat};

    ctl3w_sync #(
        .WIDTH   (NLINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (lines_raw),
        .dout  (lines_s)
    );

    ctl3w_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s[2]),
        .sdat_s   (lines_s[0]),
        .latch_s  (lines_s[1]),
        .cs_n_s   (lines_s[3]),
        .word_o   (word),
        .wr_stb_o (wr_stb)
    );

    ctl3w_regbank u_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .word   (word),
        .regs_o (regs)
    );

    assign atten_l      = regs.atten_l;
    assign load_l       = regs.load_l;
    assign atten_r      = regs.atten_r;
    assign load_r       = regs.load_r;
    assign soft_mute    = regs.soft_mute;
    assign deemph_en    = regs.deemph_en;
    assign force_zero   = regs.force_zero;
    assign word_len     = regs.word_len;
    assign fmt_i2s      = regs.fmt_i2s;
    assign lr_pol       = regs.lr_pol;
    assign atten_common = regs.atten_common;
    assign slow_rolloff = regs.slow_rolloff;
    assign phase_rev    = regs.phase_rev;
    assign clkout_div   = regs.clkout_div;
    assign deemph_rate  = regs.deemph_rate;
    assign zero_det_en  = regs.zero_det_en;
    assign diff_mode    = regs.diff_mode;
    assign clkloss_dis  = regs.clkloss_dis;

endmodule

// File: tb/ctl3w_port_bench.sv
module ctl3w_port_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_latch = 1'b0;

    logic [7:0] atten_l, atten_r;
    logic       load_l, load_r, soft_mute, deemph_en, force_zero;
    logic [1:0] word_len, deemph_rate, diff_mode;
    logic       fmt_i2s, lr_pol, atten_common, slow_rolloff, phase_rev, clkout_div;
    logic       zero_det_en, clkloss_dis;

    always #5 clk = ~clk;

    ctl3w_port u_ctl3w_port (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n),
        .ser_clk (ser_clk), .ser_dat (ser_dat), .ser_latch (ser_latch),
        .atten_l (atten_l), .load_l (load_l), .atten_r (atten_r), .load_r (load_r),
        .soft_mute (soft_mute), .deemph_en (deemph_en), .force_zero (force_zero),
        .word_len (word_len), .fmt_i2s (fmt_i2s), .lr_pol (lr_pol),
        .atten_common (atten_common), .slow_rolloff (slow_rolloff),
        .phase_rev (phase_rev), .clkout_div (clkout_div), .deemph_rate (deemph_rate),
        .zero_det_en (zero_det_en), .diff_mode (diff_mode), .clkloss_dis (clkloss_dis)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model, derived from the requirements
    logic [7:0]  e_al = 8'hFF, e_ar = 8'hFF;
    logic        e_ll = 0, e_lr = 0, e_mute = 0, e_dem = 0, e_fz = 0;
    logic [1:0]  e_wl = 0, e_rate = 0, e_diff = 0;
    logic        e_i2s = 0, e_lrp = 0, e_ac = 0, e_slow = 0, e_rev = 0, e_cko = 0;
    logic        e_zd = 0, e_cld = 0, e_unl = 0;
    logic [15:0] m_sh = '0;

    function automatic logic [34:0] act_vec();
        return {atten_l, load_l, atten_r, load_r, soft_mute, deemph_en, force_zero,
                word_len, fmt_i2s, lr_pol, atten_common, slow_rolloff, phase_rev,
                clkout_div, deemph_rate, zero_det_en, diff_mode, clkloss_dis};
    endfunction

    function automatic logic [34:0] exp_vec();
        return {e_al, e_ll, e_ar, e_lr, e_mute, e_dem, e_fz, e_wl, e_i2s, e_lrp, e_ac,
                e_slow, e_rev, e_cko, e_rate, e_zd, e_diff, e_cld};
    endfunction

    task automatic check(input string tag);
        logic [34:0] a, e;
        a = act_vec();
        e = exp_vec();
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply(input logic [15:0] w);
        case (w[11:9])
            3'b000: begin e_al = w[7:0]; e_ll = w[8]; end
            3'b001: begin e_ar = w[7:0]; e_lr = w[8]; end
            3'b010: begin
                e_mute = w[0]; e_dem = w[1]; e_fz = w[2]; e_wl = w[4:3];
                e_unl = (w[8:5] == 4'b1111);
            end
            3'b011: begin
                e_i2s = w[0]; e_lrp = w[1]; e_ac = w[2]; e_slow = w[3];
                e_rev = w[4]; e_cko = w[5]; e_rate = w[7:6]; e_zd = w[8];
            end
            3'b110: if (e_unl) begin e_diff = w[5:4]; e_cld = w[6]; end
            default: ;
        endcase
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = v[i];
            idle(3);
            ser_clk = 1'b1;
            idle(3);
            ser_clk = 1'b0;
            if (!cs_n) m_sh = {m_sh[14:0], v[i]};
        end
    endtask

    task automatic strobe();
        idle(2);
        ser_latch = 1'b1;
        idle(3);
        ser_latch = 1'b0;
        idle(8);
        if (!cs_n) apply(m_sh);
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] dat, input string tag);
        send_bits({16'h0, 4'hA, a, dat}, 16);
        strobe();
        check(tag);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(5);
        check("R1 reset values");
        cs_n = 1'b0;
        idle(4);

        // R2: no change while shifting, change after latch
        send_bits({16'h0, 4'h0, 3'b000, 9'h112}, 16);
        idle(6);
        check("R2 before latch");
        strobe();
        check("R2 after latch");

        // R3: attenuation sweeps
        for (int i = 0; i < 256; i++) wr(3'b000, {i[0], i[7:0]}, "R3 left atten");
        for (int i = 0; i < 256; i += 4) wr(3'b001, {i[2], i[7:0]}, "R3 right atten");

        // R4: mode register A, key bits zero
        for (int i = 0; i < 32; i++) wr(3'b010, {4'b0000, i[4:0]}, "R4 mode A");

        // R5: mode register B, full sweep
        for (int i = 0; i < 512; i++) wr(3'b011, i[8:0], "R5 mode B");

        // R6: hidden write while locked
        wr(3'b110, 9'h1FF, "R6 locked hidden write");

        // R7: unlock and sweep hidden fields
        wr(3'b010, 9'b1111_00101, "R7 unlock key");
        for (int i = 0; i < 8; i++) wr(3'b110, {2'b00, i[2:0], 4'b0000}, "R7 hidden write");

        // R8: relock with non-key values
        wr(3'b010, 9'b0111_00000, "R8 relock 0111");
        wr(3'b110, 9'h070, "R8 hidden write after relock");
        wr(3'b010, 9'b1111_00000, "R7 unlock again");
        wr(3'b110, 9'h020, "R7 hidden write unlocked");
        wr(3'b010, 9'b1110_00000, "R8 relock 1110");
        wr(3'b110, 9'h050, "R8 hidden write after relock");

        // R10: unused addresses
        wr(3'b100, 9'h1FF, "R10 addr 100");
        wr(3'b101, 9'h000, "R10 addr 101");
        wr(3'b111, 9'h1FF, "R10 addr 111");
        wr(3'b110, 9'h070, "R10 lock unchanged by unused writes");

        // R9: deselected port ignores shifting and latching
        wr(3'b000, 9'h155, "R9 setup");
        cs_n = 1'b1;
        idle(4);
        wr(3'b000, 9'h0AA, "R9 deselected frame");
        wr(3'b011, 9'h1FF, "R9 deselected frame mode B");
        cs_n = 1'b0;
        idle(4);
        strobe();
        check("R9 latch without new bits");

        // R11: overlong and short frames
        send_bits({12'h0, 4'h5, 4'h0, 3'b001, 9'h134}, 20);
        strobe();
        check("R11 twenty bits");
        send_bits({20'h0, 12'h0AB}, 12);
        strobe();
        check("R11 twelve bits");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1800000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL all requirements: watchdog expired actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule